// File: doc/BRIEF.md
# System Control Register Coprocessor

This block is a small control coprocessor placed beside a CPU core. The core reaches it with register-transfer requests: a write request moves a 32-bit word from the core into one of eight coprocessor registers, and a read request returns a register's contents. The register is picked by a three-bit index taken from the instruction word. Register 0 always reads as a fixed identification word. Register 1 holds four mode bits that are driven straight back to the core: program address width, data address width, abort timing and byte order. Registers 2 to 7 are plain storage.

At reset, register 1's mode bits are loaded from the core's current mode pins, so the coprocessor starts in agreement with the core. Each write to register 1, from either port, updates the mode outputs and raises a one-cycle "mode changed" strobe so the core picks up the new setting at once. A separate debug port reads registers combinationally and writes them by index, without going through the instruction path. Memory-transfer and data-operation requests are not handled. They are answered with a "cannot" response.

Top module: `sysctl_cp`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rsp_valid` clears, `rsp_code` becomes 0 and `rsp_rdata` becomes zero. Registers 2 to 7 clear to zero. Register 1 loads {24'b0, bigend, lateabt, data32, prog32, 4'b0} from the `core_*_in` pins, and `mode_changed` clears.
- R2: The register index of an instruction request is `req_instr[18:16]`. Bit 19 and all other instruction bits have no effect on which register is addressed.
- R3: A request with `req_kind` = 0 (write transfer) stores `req_wdata` in the indexed register at the clock edge. In the cycle after that edge, `rsp_valid` = 1, `rsp_code` = 1 (done) and `rsp_rdata` = 0.
- R4: A request with `req_kind` = 1 (read transfer) gives `rsp_valid` = 1, `rsp_code` = 1 and `rsp_rdata` equal to the register's value before the edge, in the cycle after the edge. Cycles without a request give `rsp_valid` = 0 and `rsp_code` = 0.
- R5: Register 0 reads 32'h41440110 through both ports at all times. Writes to it have no effect.
- R6: `mode_prog32`, `mode_data32`, `mode_lateabt` and `mode_bigend` equal register 1 bits 4, 5, 6 and 7. A write takes effect in the cycle after its edge. Bits 3:0 and 31:8 of register 1 are stored but drive nothing.
- R7: `mode_changed` is high for exactly the one cycle after each edge at which register 1 is written by either port, even if the value is unchanged. It is low at all other times.
- R8: A request with `req_kind` = 2 (memory transfer) or 3 (data operation) gives `rsp_valid` = 1, `rsp_code` = 2 (cannot) and `rsp_rdata` = 0 in the next cycle, and changes no register.
- R9: `dbg_rdata` shows, in the same cycle, the register selected by `dbg_idx` (4 bits). Indices 8 to 15 read as zero.
- R10: When `dbg_wr` is high, `dbg_wdata` is written to the register at `dbg_idx` at the clock edge. Indices 8 to 15 are ignored.
- R11: When an instruction write and a debug write hit the same register at the same edge, the instruction write is kept. Writes to different registers at the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_prog32_in | input | 1 | Core's program-width setting, sampled at reset |
| core_data32_in | input | 1 | Core's data-width setting, sampled at reset |
| core_lateabt_in | input | 1 | Core's abort-timing setting, sampled at reset |
| core_bigend_in | input | 1 | Core's byte-order setting, sampled at reset |
| req_valid | input | 1 | Instruction request present this cycle |
| req_kind | input | 2 | 0 write transfer, 1 read transfer, 2 memory transfer, 3 data operation |
| req_instr | input | 32 | Instruction word; bits 18:16 pick the register |
| req_wdata | input | 32 | Data for a write transfer |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 0 idle, 1 done, 2 cannot |
| rsp_rdata | output | 32 | Read-transfer result |
| dbg_wr | input | 1 | Debug write strobe |
| dbg_idx | input | 4 | Debug register index |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data (combinational) |
| mode_prog32 | output | 1 | Program address width mode bit |
| mode_data32 | output | 1 | Data address width mode bit |
| mode_lateabt | output | 1 | Late abort timing mode bit |
| mode_bigend | output | 1 | Big-endian mode bit |
| mode_changed | output | 1 | One-cycle strobe after a register 1 write |

## Verification
Instruction responses, mode outputs and the mode-changed strobe all come out one edge after the request. The bench therefore drives each step just after a falling edge and checks these results 1 ns after the next rising edge. Debug reads are combinational, so they are checked 1 ns after the inputs are driven, before the edge that commits any write in the same step. The reference model is updated only after the pre-edge values have been captured, so read responses are compared against the register contents as they stood before the edge.

// File: rtl/sysctl_cp_pkg.sv
// Package: shared constants and encodings for the system control coprocessor.
// Assumes: 32-bit data path; request and response codes fixed as listed here.
package sysctl_cp_pkg;
    localparam logic [31:0] CP_ID_WORD = 32'h41440110;

    typedef enum logic [1:0] {
        KIND_WRITE  = 2'd0,
        KIND_READ   = 2'd1,
        KIND_MEMXFR = 2'd2,
        KIND_DATAOP = 2'd3
    } req_kind_t;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_DONE = 2'd1,
        RSP_CANT = 2'd2
    } rsp_code_t;
endpackage

// File: rtl/sysctl_cp_regfile.sv
// Module: register storage with two write ports and two read ports.
// Register 0 has no storage and reads as the ID word. Register 1 resets to
// the value on reset_r1; others reset to zero. Port A wins over port B when
// both write the same register at one edge.
module sysctl_cp_regfile
    import sysctl_cp_pkg::*;
#(
    parameter int NREG = 8,
    parameter int W    = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  reset_r1,
    input  logic          wa_en,
    input  logic [IW-1:0] wa_idx,
    input  logic [W-1:0]  wa_data,
    input  logic          wb_en,
    input  logic [IW-1:0] wb_idx,
    input  logic [W-1:0]  wb_data,
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb_data,
    output logic [W-1:0]  r1_q
);
    logic [W-1:0] view [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == 0) begin : g_id
            assign view[i] = CP_ID_WORD;
        end else begin : g_store
            logic [W-1:0] q;
            logic hit_a, hit_b;
            assign hit_a = wa_en && (wa_idx == IW'(i));
            assign hit_b = wb_en && (wb_idx == IW'(i));
            // Hold one register; reset, then port A, then port B.
            always_ff @(posedge clk) begin
                if (!rst_n)     q <= (i == 1) ? reset_r1 : '0;
                else if (hit_a) q <= wa_data;
                else if (hit_b) q <= wb_data;
            end
            assign view[i] = q;
        end
    end

    // Read muxes for both ports.
    always_comb begin
        ra_data = view[ra_idx];
        rb_data = view[rb_idx];
        r1_q    = view[1];
    end

    // R11: port A keeps a same-index collision
    a_r11_port_a_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en && wa_idx == 1 && wb_idx == 1) |=> (r1_q == $past(wa_data)));
endmodule

// File: rtl/sysctl_cp_decode.sv
// Module: decodes instruction requests and registers the response.
// Assumes one request per cycle; a response appears the cycle after.
module sysctl_cp_decode
    import sysctl_cp_pkg::*;
#(
    parameter int NREG = 8,
    parameter int W    = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [3:0]    req_sel,
    input  logic [W-1:0]  rd_data,
    output logic          wr_en,
    output logic [IW-1:0] sel_idx,
    output logic          rsp_valid,
    output logic [1:0]    rsp_code,
    output logic [W-1:0]  rsp_rdata
);
    req_kind_t kind;
    logic      unused_sel;

    // Register index and write enable from the request.
    always_comb begin
        kind       = req_kind_t'(req_kind);
        sel_idx    = req_sel[IW-1:0];
        unused_sel = ^req_sel;
        wr_en      = req_valid && (kind == KIND_WRITE);
    end

    // Response register: done for transfers, cannot for the rest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_IDLE;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= '0;
            if (!req_valid) begin
                rsp_code <= RSP_IDLE;
            end else begin
                case (kind)
                    KIND_WRITE: rsp_code <= RSP_DONE;
                    KIND_READ: begin
                        rsp_code  <= RSP_DONE;
                        rsp_rdata <= rd_data;
                    end
                    default:   rsp_code <= RSP_CANT;
                endcase
            end
        end
    end

    // R8: unhandled kinds answer cannot
    a_r8_cant: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind[1]) |=> (rsp_valid && rsp_code == RSP_CANT && rsp_rdata == '0));
    // R3: write transfer answers done with zero data
    a_r3_write_done: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_WRITE) |=> (rsp_code == RSP_DONE && rsp_rdata == '0));
    // R4: idle cycle gives no response
    a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_code == RSP_IDLE));
endmodule

// File: rtl/sysctl_cp_mode.sv
// Module: drives mode bits to the core and the mode-changed strobe.
// Assumes r1_write is high in the cycle whose edge writes register 1.
module sysctl_cp_mode (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       r1_write,
    input  logic [3:0] mode_bits,
    output logic       mode_prog32,
    output logic       mode_data32,
    output logic       mode_lateabt,
    output logic       mode_bigend,
    output logic       mode_changed
);
    // Map stored bits 7:4 onto the four mode outputs.
    always_comb begin
        mode_prog32  = mode_bits[0];
        mode_data32  = mode_bits[1];
        mode_lateabt = mode_bits[2];
        mode_bigend  = mode_bits[3];
    end

    // Strobe for one cycle after each register 1 write.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_changed <= 1'b0;
        else        mode_changed <= r1_write;
    end

    // R6: mode outputs hold when register 1 is not written
    a_r6_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !r1_write |=> $stable({mode_bigend, mode_lateabt, mode_data32, mode_prog32}));
    // R7: strobe drops unless another write follows
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_changed && !r1_write) |=> !mode_changed);
endmodule

// File: rtl/sysctl_cp.sv
// Module: system control coprocessor top. Joins the request decoder, the
// register file and the mode driver, and adds the debug port.
// Assumes synchronous active-low reset; debug reads are combinational.
module sysctl_cp
    import sysctl_cp_pkg::*;
#(
    parameter int NREG = 8,
    parameter int W    = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         core_prog32_in,
    input  logic         core_data32_in,
    input  logic         core_lateabt_in,
    input  logic         core_bigend_in,
    input  logic         req_valid,
    input  logic [1:0]   req_kind,
    input  logic [31:0]  req_instr,
    input  logic [W-1:0] req_wdata,
    output logic         rsp_valid,
    output logic [1:0]   rsp_code,
    output logic [W-1:0] rsp_rdata,
    input  logic         dbg_wr,
    input  logic [3:0]   dbg_idx,
    input  logic [W-1:0] dbg_wdata,
    output logic [W-1:0] dbg_rdata,
    output logic         mode_prog32,
    output logic         mode_data32,
    output logic         mode_lateabt,
    output logic         mode_bigend,
    output logic         mode_changed
);
    logic          ins_wr;
    logic [IW-1:0] ins_idx;
    logic [W-1:0]  ins_rd;
    logic          dbg_in_range;
    logic          dbg_we;
    logic [IW-1:0] dbg_sel;
    logic [W-1:0]  dbg_rd;
    logic [W-1:0]  reset_r1;
    logic [W-1:0]  r1_q;
    logic          r1_write;
    logic          unused_instr;

    // Debug range check, reset image and register 1 write detect.
    always_comb begin
        dbg_in_range = (32'(dbg_idx) < NREG);
        dbg_we       = dbg_wr && dbg_in_range;
        dbg_sel      = dbg_idx[IW-1:0];
        dbg_rdata    = dbg_in_range ? dbg_rd : '0;
        reset_r1     = '0;
        reset_r1[7:4] = {core_bigend_in, core_lateabt_in, core_data32_in, core_prog32_in};
        r1_write     = (ins_wr && ins_idx == IW'(1)) || (dbg_we && dbg_sel == IW'(1));
        unused_instr = ^{req_instr[31:20], req_instr[15:0]};
    end

    sysctl_cp_decode #(.NREG(NREG), .W(W)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_sel   (req_instr[19:16]),
        .rd_data   (ins_rd),
        .wr_en     (ins_wr),
        .sel_idx   (ins_idx),
        .rsp_valid (rsp_valid),
        .rsp_code  (rsp_code),
        .rsp_rdata (rsp_rdata)
    );

    sysctl_cp_regfile #(.NREG(NREG), .W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reset_r1 (reset_r1),
        .wa_en    (ins_wr),
        .wa_idx   (ins_idx),
        .wa_data  (req_wdata),
        .wb_en    (dbg_we),
        .wb_idx   (dbg_sel),
        .wb_data  (dbg_wdata),
        .ra_idx   (ins_idx),
        .ra_data  (ins_rd),
        .rb_idx   (dbg_sel),
        .rb_data  (dbg_rd),
        .r1_q     (r1_q)
    );

    sysctl_cp_mode u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .r1_write     (r1_write),
        .mode_bits    (r1_q[7:4]),
        .mode_prog32  (mode_prog32),
        .mode_data32  (mode_data32),
        .mode_lateabt (mode_lateabt),
        .mode_bigend  (mode_bigend),
        .mode_changed (mode_changed)
    );

    // R5: debug read of index 0 gives the ID word
    a_r5_dbg_id: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_idx == 4'd0) |-> (dbg_rdata == CP_ID_WORD));
    // R9: out-of-range debug reads return zero
    a_r9_dbg_range: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_idx[3] |-> (dbg_rdata == '0));
    // R7: a register 1 write raises the strobe next cycle
    a_r7_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        r1_write |=> mode_changed);
    // R6: instruction write to register 1 shows on the mode pins
    a_r6_mode_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd0 && req_instr[18:16] == 3'd1) |=>
        ({mode_bigend, mode_lateabt, mode_data32, mode_prog32} == $past(req_wdata[7:4])));
endmodule

// File: tb/sysctl_cp_tb_top.sv
module sysctl_cp_tb_top;
    localparam logic [31:0] ID = 32'h41440110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        c_p32 = 1'b0, c_d32 = 1'b0, c_la = 1'b0, c_be = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [31:0] req_instr = '0, req_wdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_rdata;
    logic        dbg_wr = 1'b0;
    logic [3:0]  dbg_idx = '0;
    logic [31:0] dbg_wdata = '0, dbg_rdata;
    logic        m_p32, m_d32, m_la, m_be, m_chg;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mdl [8];

    always #4 clk = ~clk;

    sysctl_cp dut_i (
        .clk(clk), .rst_n(rst_n),
        .core_prog32_in(c_p32), .core_data32_in(c_d32),
        .core_lateabt_in(c_la), .core_bigend_in(c_be),
        .req_valid(req_valid), .req_kind(req_kind), .req_instr(req_instr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_rdata(rsp_rdata), .dbg_wr(dbg_wr), .dbg_idx(dbg_idx),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .mode_prog32(m_p32), .mode_data32(m_d32), .mode_lateabt(m_la),
        .mode_bigend(m_be), .mode_changed(m_chg)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_reg(input logic [2:0] i);
        return (i == 3'd0) ? ID : mdl[i];
    endfunction

    function automatic logic [31:0] exp_dbg(input logic [3:0] i);
        return i[3] ? 32'h0 : exp_reg(i[2:0]);
    endfunction

    // One step: drive after negedge, check debug read, edge, check results.
    task automatic step(input bit v, input logic [1:0] k, input logic [31:0] ins,
                        input logic [31:0] wd, input bit dw, input logic [3:0] di,
                        input logic [31:0] dd);
        logic [31:0] exp_rd;
        logic [2:0]  ri;
        bit          r1w;
        @(negedge clk);
        req_valid = v; req_kind = k; req_instr = ins; req_wdata = wd;
        dbg_wr = dw; dbg_idx = di; dbg_wdata = dd;
        #1;
        chk(dbg_rdata == exp_dbg(di), "R9", dbg_rdata, exp_dbg(di));
        ri = ins[18:16];
        exp_rd = exp_reg(ri);
        r1w = 1'b0;
        if (dw && !di[3] && di[2:0] != 3'd0) begin
            if (!(v && k == 2'd0 && ri == di[2:0])) mdl[di[2:0]] = dd;
            if (di[2:0] == 3'd1) r1w = 1'b1;
        end
        if (v && k == 2'd0 && ri != 3'd0) begin
            mdl[ri] = wd;
            if (ri == 3'd1) r1w = 1'b1;
        end
        @(posedge clk); #1;
        if (!v) begin
            chk(!rsp_valid && rsp_code == 2'd0, "R4", {30'd0, rsp_code}, 32'd0);
        end else if (k[1]) begin
            chk(rsp_valid && rsp_code == 2'd2 && rsp_rdata == 0, "R8", rsp_rdata, 32'd0);
        end else if (k == 2'd0) begin
            chk(rsp_valid && rsp_code == 2'd1 && rsp_rdata == 0, "R3", {30'd0, rsp_code}, 32'd1);
        end else begin
            chk(rsp_valid && rsp_code == 2'd1 && rsp_rdata == exp_rd, "R4", rsp_rdata, exp_rd);
        end
        chk({m_be, m_la, m_d32, m_p32} == mdl[1][7:4], "R6",
            {28'd0, m_be, m_la, m_d32, m_p32}, {28'd0, mdl[1][7:4]});
        chk(m_chg == r1w, "R7", {31'd0, m_chg}, {31'd0, r1w});
    endtask

    // Read every register back through the debug port (R10, R11 state).
    task automatic sweep(input string req);
        @(negedge clk);
        req_valid = 1'b0; dbg_wr = 1'b0;
        for (int i = 0; i < 16; i++) begin
            dbg_idx = 4'(i); #0.5;
            chk(dbg_rdata == exp_dbg(4'(i)), req, dbg_rdata, exp_dbg(4'(i)));
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset with mode pins 1,0,1,1 (prog32, data32, lateabt, bigend)
        c_p32 = 1'b1; c_d32 = 1'b0; c_la = 1'b1; c_be = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        c_p32 = 1'b0; c_la = 1'b0; c_be = 1'b0;
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        mdl[1] = 32'h000000D0;
        #1;
        chk(!rsp_valid && rsp_code == 0 && rsp_rdata == 0, "R1", rsp_rdata, 32'd0);
        chk({m_be, m_la, m_d32, m_p32} == 4'b1101, "R1",
            {28'd0, m_be, m_la, m_d32, m_p32}, 32'hD);
        chk(!m_chg, "R1", {31'd0, m_chg}, 32'd0);
        sweep("R1");

        // R5: write to reg 0 both ways, read ID back
        step(1, 2'd0, 32'h0000_0000, 32'hDEAD_BEEF, 0, 0, 0);
        step(1, 2'd1, 32'h0000_0000, 0, 1, 4'd0, 32'h1111_1111);
        step(1, 2'd1, 32'h0000_0000, 0, 0, 0, 0);
        // R2: bit 19 ignored, index 1+8 hits register 1
        step(1, 2'd0, 32'hFFF9_FFFF, 32'h0000_00A5, 0, 0, 0);
        step(1, 2'd1, 32'h0001_0000, 0, 0, 0, 0);
        // R7: same-value rewrite still strobes, then idle
        step(1, 2'd0, 32'h0001_0000, 32'h0000_00A5, 0, 0, 0);
        step(0, 2'd0, 0, 0, 0, 0, 0);
        // R8: memory and data-op forms change nothing
        step(1, 2'd2, 32'h0003_0000, 32'h1234_5678, 0, 0, 0);
        step(1, 2'd3, 32'h0001_0000, 32'h0000_0000, 0, 0, 0);
        sweep("R8");
        // R10: out-of-range debug writes ignored
        step(0, 0, 0, 0, 1, 4'd9, 32'hCAFE_0000);
        step(0, 0, 0, 0, 1, 4'd15, 32'hCAFE_0001);
        sweep("R10");
        // R11: collision on reg 1, then on reg 5, then different registers
        step(1, 2'd0, 32'h0001_0000, 32'h0000_0030, 1, 4'd1, 32'h0000_00C0);
        step(1, 2'd0, 32'h0005_0000, 32'h5555_0000, 1, 4'd5, 32'h6666_0000);
        step(1, 2'd0, 32'h0002_0000, 32'h2222_2222, 1, 4'd1, 32'h0000_00F0);
        sweep("R11");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ins;
            ins = $urandom;
            step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), ins, $urandom,
                 $urandom_range(0, 2) == 0, 4'($urandom_range(0, 15)), $urandom);
        end
        sweep("R3");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule